// File: doc/BRIEF.md
# Operand Forwarding Multiplexer

This block chooses the source operand handed to the decode stage of a four-slot pipelined core. The operand comes either from the register file read port or from one of eight in-flight pipeline results. Four of those results sit in the execute stage and four in the write-back stage. Each result carries a 6-bit destination register number and a valid flag.

Eight comparators check every destination number against the decode-stage source register number. Each comparator is qualified by its valid flag. A priority encoder turns the comparator hits into a 4-bit select. A nine-way multiplexer then delivers the chosen 16-bit value.

A parameter picks between a purely combinational output and a registered output that appears one clock later.

Top module: `bypass_fwd_unit`

## Requirements
- R1: Pipeline entries are indexed 0 to 7: indices 0 to 3 are execute slots 0 to 3, and indices 4 to 7 are write-back slots 0 to 3. Entry i occupies data bits [16i+15:16i], destination bits [6i+5:6i] and valid bit i. The internal select value is 0 for the read port and i+1 for entry i.
- R2: When no valid entry's destination equals the source register number, the output equals the read-port value.
- R3: An entry whose valid bit is 0 is never forwarded, even when its destination equals the source number.
- R4: When exactly one valid entry matches, the output equals that entry's data, for each of the eight entries.
- R5: When several valid entries match, the entry with the lowest index is forwarded. Execute entries therefore win over write-back entries, and a lower slot wins within a stage.
- R6: The comparison uses all six bits. A destination that differs from the source in any single bit does not cause forwarding.
- R7: With REG_OUT=1 (the default), the output shows the selection for the inputs present at the previous rising clock edge. While rst_n is low, the output is 0.
- R8: With REG_OUT=0, the output follows the inputs combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| src_reg | input | 6 | Source register number in decode |
| rp_data | input | 16 | Value read from the register file |
| pipe_data | input | 128 | Eight packed pipeline result values |
| pipe_dst | input | 48 | Eight packed destination register numbers |
| pipe_vld | input | 8 | Valid flag per pipeline entry |
| operand_out | output | 16 | Selected operand |

## Verification
A comparator stuck at hit, or one that ignores its valid flag, shows up as a forwarded value where the read-port value is expected. A comparator stuck at miss shows up as the read-port value where a forward is expected. Both appear at the output in the same cycle in the combinational variant and one edge later in the registered variant. A wrong priority order only becomes visible when two or more valid entries match at once, so those overlapping cases are driven on purpose. One-bit-different destination numbers on every bit position expose a comparator that drops a bit.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  parameter int unsigned DEF_DATA_W = 16;
  parameter int unsigned DEF_REG_AW = 6;
  parameter int unsigned DEF_SLOTS  = 4;
  parameter int unsigned DEF_STAGES = 2;

  // mask of all entry indices strictly below the entry chosen by sel
  function automatic logic [31:0] lower_mask(input int unsigned sel);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++)
      if (i + 1 < int'(sel)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/byp_cmp.sv
module byp_cmp #(
  parameter int unsigned AW = 6
) (
  input  logic [AW-1:0] dst,
  input  logic [AW-1:0] src,
  input  logic          vld,
  output logic          hit
);
  always_comb hit = vld && (dst == src);
endmodule

// File: rtl/byp_prio_enc.sv
module byp_prio_enc #(
  parameter int unsigned N     = 8,
  parameter int unsigned SEL_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     hits,
  output logic [SEL_W-1:0] sel,
  output logic [N-1:0]     grant
);
  always_comb begin
    sel   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        sel   = SEL_W'(i + 1);
        grant = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/byp_mux.sv
module byp_mux #(
  parameter int unsigned N     = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned SEL_W = $clog2(N + 1)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    rp,
  input  logic [N*DW-1:0]  ent,
  output logic [DW-1:0]    y
);
  always_comb begin
    y = rp;
    for (int i = 0; i < N; i++)
      if (sel == SEL_W'(i + 1)) y = ent[i*DW +: DW];
  end
endmodule

// File: rtl/bypass_fwd_unit.sv
module bypass_fwd_unit
  import bypass_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned REG_AW  = DEF_REG_AW,
  parameter int unsigned SLOTS   = DEF_SLOTS,
  parameter int unsigned STAGES  = DEF_STAGES,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [REG_AW-1:0]                 src_reg,
  input  logic [DATA_W-1:0]                 rp_data,
  input  logic [SLOTS*STAGES*DATA_W-1:0]    pipe_data,
  input  logic [SLOTS*STAGES*REG_AW-1:0]    pipe_dst,
  input  logic [SLOTS*STAGES-1:0]           pipe_vld,
  output logic [DATA_W-1:0]                 operand_out
);
  localparam int unsigned N     = SLOTS * STAGES;
  localparam int unsigned SEL_W = $clog2(N + 1);

  logic [N-1:0]      hit_vec;
  logic [N-1:0]      grant_vec;
  logic [SEL_W-1:0]  fwd_sel;
  logic [DATA_W-1:0] mux_val;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    byp_cmp #(.AW(REG_AW)) cmp_i (
      .dst (pipe_dst[g*REG_AW +: REG_AW]),
      .src (src_reg),
      .vld (pipe_vld[g]),
      .hit (hit_vec[g])
    );
  end

  byp_prio_enc #(.N(N), .SEL_W(SEL_W)) enc_i (
    .hits  (hit_vec),
    .sel   (fwd_sel),
    .grant (grant_vec)
  );

  byp_mux #(.N(N), .DW(DATA_W), .SEL_W(SEL_W)) mux_i (
    .sel (fwd_sel),
    .rp  (rp_data),
    .ent (pipe_data),
    .y   (mux_val)
  );

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q <= '0;
      else        q <= mux_val;
    assign operand_out = q;

    // R7: registered output lags the selection by one edge
    p_reg_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> operand_out == $past(mux_val));
  end else begin : g_comb
    assign operand_out = mux_val;
  end

  // R5: at most one entry granted
  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R2: no hit keeps the read port
  p_no_hit_rp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |-> (fwd_sel == '0 && mux_val == rp_data));

  // R3: a chosen entry is valid and its number matches
  p_sel_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel != '0) |-> (pipe_vld[fwd_sel - 1'b1] &&
      pipe_dst[(fwd_sel - 1'b1)*REG_AW +: REG_AW] == src_reg));

  // R5: no lower-index entry hits when one is chosen
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel != '0) |-> ((hit_vec & N'(lower_mask(fwd_sel))) == '0));
endmodule

// File: tb/bypass_fwd_unit_tb_top.sv
`timescale 1ns/1ps
module bypass_fwd_unit_tb_top;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]      src_reg = '0;
  logic [15:0]     rp_data = '0;
  logic [N*16-1:0] pipe_data = '0;
  logic [N*6-1:0]  pipe_dst = '0;
  logic [N-1:0]    pipe_vld = '0;
  logic [15:0]     out_reg, out_cmb;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bypass_fwd_unit dut_i (.clk(clk), .rst_n(rst_n), .src_reg(src_reg), .rp_data(rp_data),
    .pipe_data(pipe_data), .pipe_dst(pipe_dst), .pipe_vld(pipe_vld), .operand_out(out_reg));
  bypass_fwd_unit #(.REG_OUT(1'b0)) dut_c (.clk(clk), .rst_n(rst_n), .src_reg(src_reg),
    .rp_data(rp_data), .pipe_data(pipe_data), .pipe_dst(pipe_dst), .pipe_vld(pipe_vld),
    .operand_out(out_cmb));

  function automatic logic [15:0] model(input logic [5:0] s, input logic [15:0] rp,
      input logic [N*16-1:0] d, input logic [N*6-1:0] t, input logic [N-1:0] v);
    for (int i = 0; i < N; i++)
      if (v[i] && t[i*6 +: 6] == s) return d[i*16 +: 16];
    return rp;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, check comb mid-cycle, registered after next edge
  task automatic apply(input string tag, input logic [5:0] s, input logic [15:0] rp,
      input logic [N*16-1:0] d, input logic [N*6-1:0] t, input logic [N-1:0] v);
    logic [15:0] e;
    @(negedge clk);
    src_reg = s; rp_data = rp; pipe_data = d; pipe_dst = t; pipe_vld = v;
    e = model(s, rp, d, t, v);
    #2 chk({tag, " R8 comb"}, out_cmb, e);
    @(posedge clk); #3;
    chk({tag, " R7 reg"}, out_reg, e);
  endtask

  function automatic logic [N*16-1:0] mk_data(input logic [7:0] base);
    logic [N*16-1:0] d;
    for (int i = 0; i < N; i++) d[i*16 +: 16] = {base, 8'(8'hA0 + i)};
    return d;
  endfunction

  function automatic logic [N*6-1:0] all_dst(input logic [5:0] x);
    logic [N*6-1:0] t;
    for (int i = 0; i < N; i++) t[i*6 +: 6] = x;
    return t;
  endfunction

  task automatic t_reset;
    #5 chk("R7 reset value", out_reg, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_no_match;  // R2
    logic [N*6-1:0] t;
    for (int i = 0; i < N; i++) t[i*6 +: 6] = 6'(i + 1);
    apply("R2 no match", 6'd40, 16'h1234, mk_data(8'h11), t, 8'hFF);
    chk("R2 read port", out_cmb, 16'h1234);
  endtask

  task automatic t_invalid;  // R3
    apply("R3 all invalid", 6'd9, 16'hBEEF, mk_data(8'h22), all_dst(6'd9), 8'h00);
    chk("R3 no forward", out_cmb, 16'hBEEF);
    apply("R3 low invalid", 6'd9, 16'hBEEF, mk_data(8'h22), all_dst(6'd9), 8'hF0);
    chk("R3 wb0 chosen", out_cmb, 16'h22A4);
  endtask

  task automatic t_single;  // R4, R1 index order
    for (int k = 0; k < N; k++) begin
      logic [N*6-1:0] t;
      t = all_dst(6'd5);
      t[k*6 +: 6] = 6'd63;
      apply("R4 single", 6'd63, 16'h0F0F, mk_data(8'h33), t, 8'hFF);
      chk("R1 R4 entry data", out_cmb, {8'h33, 8'(8'hA0 + k)});
    end
  endtask

  task automatic t_priority;  // R5
    apply("R5 ex1 over wb", 6'd0, 16'h0, mk_data(8'h44), all_dst(6'd0), 8'b1111_0010);
    chk("R5 ex1", out_cmb, 16'h44A1);
    apply("R5 wb2 over wb3", 6'd0, 16'h0, mk_data(8'h44), all_dst(6'd0), 8'b1100_0000);
    chk("R5 wb2", out_cmb, 16'h44A6);
    apply("R5 ex0 all", 6'd0, 16'h0, mk_data(8'h55), all_dst(6'd0), 8'hFF);
    chk("R5 ex0", out_cmb, 16'h55A0);
  endtask

  task automatic t_one_bit;  // R6
    for (int b = 0; b < 6; b++) begin
      apply("R6 one bit off", 6'd21, 16'hC0DE, mk_data(8'h66),
            all_dst(6'd21 ^ 6'(1 << b)), 8'hFF);
      chk("R6 no forward", out_cmb, 16'hC0DE);
    end
  endtask

  initial begin
    #199990;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_no_match();
    t_invalid();
    t_single();
    t_priority();
    t_one_bit();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule